// File: doc/BRIEF.md
# Tiered Priority Memory Arbiter

This block decides which of several requesters gets the next transaction on one shared memory port. There are three kinds of requester. Memory maintenance covers refresh and page upkeep. Display-output engines must meet real-time deadlines. General masters make up the rest. Maintenance always wins. Display engines sit in the top requester tier. Each general master is placed in a middle or a low tier by a configuration input. One display engine can instead be moved into any of the three requester tiers. Requesters that share a tier take turns in round-robin order. Each tier keeps its own turn pointer.

The arbiter decides only when the port is idle. It looks at the requests present on that clock edge, issues a registered one-hot grant, and holds that grant until the memory side pulses `done_i`. Two filters remove requests before the decision:

- While an NMI is being serviced, requesters chosen by a mask input are blocked, which gives the CPU a larger share of the bandwidth.
- Requesters that are built as SDRAM-only are never granted a transaction aimed at SRAM.

An internal interval timer raises a refresh-pending flag. The flag saturates and is cleared when a maintenance grant is issued.

Top module: `tiered_mem_arbiter`

## Requirements
- R1: When the port is idle and `page_req_i` is high or a refresh is pending, the next grant is `maint_gnt_o`, whatever requests are present.
- R2: With `refresh_iv_i` = K > 0, a refresh becomes pending K cycles after the last maintenance grant. Missed intervals collapse into one pending refresh, and K = 0 stops the timer.
- R3: Display requesters (indices 0 to N_DISP-1) in tier 1 win over every general requester.
- R4: General requester N_DISP+k is in tier 3 when `gen_lo_tier_i[k]` is 1 and in tier 2 when it is 0. A tier-2 request beats a tier-3 request.
- R5: The last display requester (index N_DISP-1) takes its tier from `disp_tier_i`: 0 or 1 gives tier 1, 2 gives tier 2, and 3 gives tier 3.
- R6: Within a tier, the grant goes to the first eligible requester after the one that tier granted last, searching upward with wrap-around. After reset each tier starts its search at index 0.
- R7: A decision uses only the requests present on the idle edge. The grant is held unchanged until `done_i` is sampled high, and it drops to zero on that edge. Requests that change while the grant is held have no effect.
- R8: While `nmi_active_i` is 1, requester i is never granted if `nmi_mask_i[i]` is 1. While `nmi_active_i` is 0 the mask has no effect.
- R9: A requester whose bit in SDRAM_ONLY_MASK is set is never granted while its `tgt_sram_i` bit (1 = SRAM, 0 = SDRAM) is 1. Other requesters may target SRAM.
- R10: After reset no grant is active. At most one of `gnt_o` and `maint_gnt_o` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DISP+N_GEN | Request line per requester |
| tgt_sram_i | input | N_DISP+N_GEN | Target per request: 1 = SRAM, 0 = SDRAM |
| gen_lo_tier_i | input | N_GEN | Tier select per general requester: 1 = tier 3, 0 = tier 2 |
| disp_tier_i | input | 2 | Tier of the selectable display requester |
| nmi_mask_i | input | N_DISP+N_GEN | Requesters blocked during NMI service |
| nmi_active_i | input | 1 | NMI service in progress |
| refresh_iv_i | input | CNT_W | Refresh interval in cycles (0 = timer off) |
| page_req_i | input | 1 | Page maintenance request |
| done_i | input | 1 | Current transaction finished |
| gnt_o | output | N_DISP+N_GEN | One-hot requester grant |
| maint_gnt_o | output | 1 | Maintenance grant |

## Verification
Suppose a tier's turn pointer is corrupted or advances on the wrong win. The first repeated run of same-tier requests then produces a grant sequence out of order, and this shows on `gnt_o` on the very next arbitration. Suppose instead the refresh flag fails to saturate or fails to clear. The port then shows either a second back-to-back maintenance grant or a refresh that is never granted, and either appears within one interval plus two cycles of the missed edge. If a hold or release fault occurs, or a masked or SRAM-blocked requester is granted, it appears in the same cycle as the faulty edge.

// File: rtl/tma_pkg.sv
package tma_pkg;
  typedef enum logic [1:0] {
    TIER_MAINT = 2'd0,
    TIER_DISP  = 2'd1,
    TIER_HI    = 2'd2,
    TIER_LO    = 2'd3
  } tier_e;

  localparam int unsigned NUM_REQ_TIERS = 3;
endpackage

// File: rtl/tma_refresh_timer.sv
module tma_refresh_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] interval_i,
  input  logic             clr_i,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (interval_i == '0) begin
      cnt_q <= '0;
    end else if (cnt_q >= interval_i - CNT_W'(1)) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;  // saturate: missed intervals collapse
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/tma_rr_pick.sv
module tma_rr_pick #(
  parameter int unsigned N     = 6,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  int j;

  // scan from farthest to nearest so the nearest hit after ptr_i wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    j       = 0;
    for (int off = N; off >= 1; off--) begin
      j = (int'(ptr_i) + off) % N;
      if (req_i[j]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/tiered_mem_arbiter.sv
module tiered_mem_arbiter
  import tma_pkg::*;
#(
  parameter int unsigned N_DISP          = 2,
  parameter int unsigned N_GEN           = 4,
  parameter int unsigned CNT_W           = 16,
  parameter int unsigned SDRAM_ONLY_MASK = 32'h0000_0007,
  localparam int unsigned N              = N_DISP + N_GEN,
  localparam int unsigned IDX_W          = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     tgt_sram_i,
  input  logic [N_GEN-1:0] gen_lo_tier_i,
  input  logic [1:0]       disp_tier_i,
  input  logic [N-1:0]     nmi_mask_i,
  input  logic             nmi_active_i,
  input  logic [CNT_W-1:0] refresh_iv_i,
  input  logic             page_req_i,
  input  logic             done_i,
  output logic [N-1:0]     gnt_o,
  output logic             maint_gnt_o
);
  localparam int unsigned NT = NUM_REQ_TIERS;
  localparam logic [N-1:0] SD_ONLY = N'(SDRAM_ONLY_MASK);

  tier_e            tier_of [N];
  logic [N-1:0]     eligible;
  logic [N-1:0]     member  [NT];
  logic             t_valid [NT];
  logic [IDX_W-1:0] t_idx   [NT];
  logic [IDX_W-1:0] ptr_q   [NT];
  logic [N-1:0]     gnt_q;
  logic             maint_q;
  logic             idle;
  logic             refresh_pend;
  logic             maint_req;
  logic             maint_issue;
  logic             win_valid;
  int unsigned      win_tier;
  logic [IDX_W-1:0] win_idx;

  // tier assignment per requester
  for (genvar i = 0; i < N; i++) begin : g_tier
    if (i == N_DISP - 1) begin : g_sel_disp
      always_comb tier_of[i] = (disp_tier_i < 2'd2) ? TIER_DISP : tier_e'(disp_tier_i);
    end else if (i < N_DISP) begin : g_fix_disp
      always_comb tier_of[i] = TIER_DISP;
    end else begin : g_gen
      always_comb tier_of[i] = gen_lo_tier_i[i-N_DISP] ? TIER_LO : TIER_HI;
    end
  end

  assign eligible = req_i
                  & ~({N{nmi_active_i}} & nmi_mask_i)
                  & ~(tgt_sram_i & SD_ONLY);

  for (genvar t = 0; t < NT; t++) begin : g_tier_rr
    for (genvar i = 0; i < N; i++) begin : g_mem
      assign member[t][i] = eligible[i] && (tier_of[i] == tier_e'(t + 1));
    end
    tma_rr_pick #(.N(N)) u_pick (
      .req_i  (member[t]),
      .ptr_i  (ptr_q[t]),
      .valid_o(t_valid[t]),
      .idx_o  (t_idx[t])
    );
  end

  // fixed priority across tiers: lower tier number first
  always_comb begin
    win_valid = 1'b0;
    win_tier  = 0;
    win_idx   = '0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (t_valid[t]) begin
        win_valid = 1'b1;
        win_tier  = t;
        win_idx   = t_idx[t];
      end
    end
  end

  tma_refresh_timer #(.CNT_W(CNT_W)) u_refresh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .interval_i(refresh_iv_i),
    .clr_i     (maint_issue),
    .pend_o    (refresh_pend)
  );

  assign idle        = (gnt_q == '0) && !maint_q;
  assign maint_req   = page_req_i || refresh_pend;
  assign maint_issue = idle && maint_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q   <= '0;
      maint_q <= 1'b0;
      for (int t = 0; t < NT; t++) ptr_q[t] <= IDX_W'(N - 1);
    end else if (idle) begin
      if (maint_req) begin
        maint_q <= 1'b1;
      end else if (win_valid) begin
        gnt_q           <= N'(1) << win_idx;
        ptr_q[win_tier] <= win_idx;
      end
    end else if (done_i) begin
      gnt_q   <= '0;
      maint_q <= 1'b0;
    end
  end

  assign gnt_o       = gnt_q;
  assign maint_gnt_o = maint_q;
endmodule

// File: rtl/tma_checker.sv
module tma_checker #(
  parameter int unsigned N               = 6,
  parameter int unsigned SDRAM_ONLY_MASK = 32'h7
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] req_i,
  input logic [N-1:0] tgt_sram_i,
  input logic [N-1:0] nmi_mask_i,
  input logic         nmi_active_i,
  input logic         page_req_i,
  input logic         done_i,
  input logic [N-1:0] gnt_o,
  input logic         maint_gnt_o
);
  localparam logic [N-1:0] SD_ONLY = N'(SDRAM_ONLY_MASK);
  logic idle;
  assign idle = (gnt_o == '0) && !maint_gnt_o;

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({maint_gnt_o, gnt_o}));

  p_maint_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && page_req_i) |=> maint_gnt_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !done_i) |=> $stable({maint_gnt_o, gnt_o}));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && done_i) |=> ((gnt_o == '0) && !maint_gnt_o));

  p_only_requested_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ((gnt_o & ~$past(req_i)) == '0));

  p_nmi_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ((gnt_o & $past(nmi_mask_i) & {N{$past(nmi_active_i)}}) == '0));

  p_sdram_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ((gnt_o & $past(tgt_sram_i) & SD_ONLY) == '0));
endmodule

bind tiered_mem_arbiter tma_checker #(
  .N              (N_DISP + N_GEN),
  .SDRAM_ONLY_MASK(SDRAM_ONLY_MASK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .tgt_sram_i  (tgt_sram_i),
  .nmi_mask_i  (nmi_mask_i),
  .nmi_active_i(nmi_active_i),
  .page_req_i  (page_req_i),
  .done_i      (done_i),
  .gnt_o       (gnt_o),
  .maint_gnt_o (maint_gnt_o)
);

// File: tb/tiered_mem_arbiter_test.sv
module tiered_mem_arbiter_test;
  localparam int N = 6;

  typedef struct {
    logic [N-1:0] g;
    logic         m;
    string        tag;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] tgt_sram_i = '0;
  logic [3:0]   gen_lo_tier_i = '0;
  logic [1:0]   disp_tier_i = 2'd1;
  logic [N-1:0] nmi_mask_i = '0;
  logic         nmi_active_i = 1'b0;
  logic [15:0]  refresh_iv_i = '0;
  logic         page_req_i = 1'b0;
  logic         done_i = 1'b0;
  logic [N-1:0] gnt_o;
  logic         maint_gnt_o;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  always #4 clk_i = ~clk_i;

  tiered_mem_arbiter uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .tgt_sram_i   (tgt_sram_i),
    .gen_lo_tier_i(gen_lo_tier_i),
    .disp_tier_i  (disp_tier_i),
    .nmi_mask_i   (nmi_mask_i),
    .nmi_active_i (nmi_active_i),
    .refresh_iv_i (refresh_iv_i),
    .page_req_i   (page_req_i),
    .done_i       (done_i),
    .gnt_o        (gnt_o),
    .maint_gnt_o  (maint_gnt_o)
  );

  // monitor: compare one expected item at each falling edge
  always @(negedge clk_i) begin
    if (sb_q.size() != 0) begin
      exp_t it;
      it = sb_q.pop_front();
      n_chk++;
      if ({gnt_o, maint_gnt_o} !== {it.g, it.m}) begin
        n_fail++;
        $display("FAIL %s: gnt=%b maint=%b expected gnt=%b maint=%b",
                 it.tag, gnt_o, maint_gnt_o, it.g, it.m);
      end
    end
  end

  task automatic push(input logic [N-1:0] g, input logic m, input string tag);
    exp_t it;
    it.g = g; it.m = m; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // one arbitration from idle, then release
  task automatic arb(input logic [N-1:0] rq, input logic [N-1:0] eg,
                     input logic em, input string tag);
    @(negedge clk_i);
    req_i = rq;
    @(posedge clk_i);
    push(eg, em, tag);
    @(negedge clk_i);
    if (eg != '0 || em) begin
      done_i = 1'b1;
      @(posedge clk_i);
      push('0, 1'b0, {tag, " release"});
      @(negedge clk_i);
      done_i = 1'b0;
    end
    req_i      = '0;
    page_req_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    push('0, 1'b0, "R10 reset state");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 / R6: display tier beats general; display pair alternates
    arb(6'b111111, 6'b000001, 1'b0, "R3 display over general");
    arb(6'b111111, 6'b000010, 1'b0, "R6 tier1 rotate");
    arb(6'b111111, 6'b000001, 1'b0, "R6 tier1 wrap");

    // R4 / R6: general tiers
    arb(6'b111100, 6'b000100, 1'b0, "R6 tier2 first from index 0");
    arb(6'b111100, 6'b001000, 1'b0, "R6 tier2 rotate");
    gen_lo_tier_i = 4'b0011;
    arb(6'b111100, 6'b010000, 1'b0, "R4 tier2 beats tier3");
    arb(6'b001100, 6'b000100, 1'b0, "R4 tier3 own pointer");

    // R5: selectable display requester
    gen_lo_tier_i = 4'b1111; disp_tier_i = 2'd2;
    arb(6'b111110, 6'b000010, 1'b0, "R5 display at tier2 over tier3");
    gen_lo_tier_i = 4'b1110; disp_tier_i = 2'd3;
    arb(6'b111110, 6'b000100, 1'b0, "R5 display at tier3 loses to tier2");
    gen_lo_tier_i = 4'b1111;
    arb(6'b000110, 6'b000010, 1'b0, "R5 display rotates inside tier3");
    disp_tier_i = 2'd0;
    arb(6'b000011, 6'b000010, 1'b0, "R5 code 0 means tier1");

    // R8: NMI masking
    disp_tier_i = 2'd1; nmi_mask_i = 6'b000011; nmi_active_i = 1'b1;
    arb(6'b000111, 6'b000100, 1'b0, "R8 masked during NMI");
    nmi_active_i = 1'b0;
    arb(6'b000111, 6'b000001, 1'b0, "R8 mask idle without NMI");
    nmi_mask_i = '0;

    // R9: SDRAM-only requesters
    tgt_sram_i = 6'b000101;
    arb(6'b001101, 6'b001000, 1'b0, "R9 SRAM blocked for restricted");
    arb(6'b000001, 6'b000000, 1'b0, "R9 lone SRAM display never granted");
    tgt_sram_i = 6'b001000;
    arb(6'b001000, 6'b001000, 1'b0, "R9 general may target SRAM");
    tgt_sram_i = '0;

    // R1: maintenance first
    page_req_i = 1'b1;
    arb(6'b111111, 6'b000000, 1'b1, "R1 page maintenance wins");

    // R7: hold and sampling
    @(negedge clk_i);
    req_i = 6'b001000;
    @(posedge clk_i);
    push(6'b001000, 1'b0, "R7 grant");
    @(negedge clk_i);
    req_i = 6'b000001;
    @(posedge clk_i);
    push(6'b001000, 1'b0, "R7 hold despite new request");
    @(posedge clk_i);
    push(6'b001000, 1'b0, "R7 hold");
    @(negedge clk_i);
    done_i = 1'b1;
    @(posedge clk_i);
    push('0, 1'b0, "R7 release on done");
    @(negedge clk_i);
    done_i = 1'b0;
    @(posedge clk_i);
    push(6'b000001, 1'b0, "R7 later request served next");
    @(negedge clk_i);
    done_i = 1'b1; req_i = '0;
    @(posedge clk_i);
    push('0, 1'b0, "R7 release");
    @(negedge clk_i);
    done_i = 1'b0;

    // R2: refresh timer, saturation
    req_i = 6'b100000; refresh_iv_i = 16'd10;
    @(posedge clk_i);
    push(6'b100000, 1'b0, "R2 setup grant");
    @(negedge clk_i);
    req_i = '0;
    repeat (40) @(negedge clk_i);
    done_i = 1'b1;
    @(posedge clk_i);
    push('0, 1'b0, "R2 release");
    @(negedge clk_i);
    done_i = 1'b0; req_i = 6'b100000;
    @(posedge clk_i);
    push('0, 1'b1, "R2 pending refresh granted");
    @(negedge clk_i);
    done_i = 1'b1;
    @(posedge clk_i);
    push('0, 1'b0, "R2 refresh release");
    @(negedge clk_i);
    done_i = 1'b0;
    @(posedge clk_i);
    push(6'b100000, 1'b0, "R2 saturated: single refresh");
    @(negedge clk_i);
    done_i = 1'b1; req_i = '0;
    @(posedge clk_i);
    push('0, 1'b0, "R2 release");
    @(negedge clk_i);
    done_i = 1'b0;
    repeat (5) @(negedge clk_i);
    n_chk++;
    if (maint_gnt_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 early refresh: maint=%b expected 0", maint_gnt_o);
    end
    repeat (8) @(negedge clk_i);
    n_chk++;
    if (maint_gnt_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R2 periodic refresh: maint=%b expected 1", maint_gnt_o);
    end
    done_i = 1'b1; refresh_iv_i = '0;
    @(negedge clk_i);
    done_i = 1'b0;
    repeat (2) @(negedge clk_i);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule